// File: doc/BRIEF.md
# Multi-Mode Radix Page Table Walker

This block turns a virtual address into a physical page base. It walks a radix page table that sits in memory and reads it through a simple request/acknowledge port. Each request carries the virtual address, a supervisor flag, a store flag, a fetch flag, a two-bit translation mode and a page-table base. The mode selects one of three table layouts at run time: two levels with 10-bit indices and 4-byte entries, three levels with 9-bit indices and 8-byte entries, or four levels with 9-bit indices and 8-byte entries. Pages are 4 KiB in every mode.

The walker takes one request at a time and keeps at most one memory access outstanding. When it reaches a leaf entry it checks permissions through a 5-bit code lookup. On success it writes the entry back with the referenced flag set, and with the dirty flag set as well for a store. A leaf found above the last level maps a large page, and the untranslated low page-number bits are merged into it. The response is one pulse that gives either a page base or a fault.

Top module: `radix_walker`

## Requirements
- R1: While reset is held and after it is released, the block shows `req_ready`=1, `resp_valid`=0 and `mem_req`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the walk ends. The walk ends with `resp_valid` high for exactly one cycle, and `req_ready` returns to 1 in the cycle after that.
- R3: `req_mode` encodings are 0 for two levels with 10 index bits and 4-byte entries, 1 for three levels with 9 index bits and 8-byte entries, and 2 for four levels with 9 index bits and 8-byte entries. `mem_wide` is 1 for the 8-byte modes. Mode 3 faults with no memory access.
- R4: The virtual width W is 12 plus levels times index bits. Bits W-1 up to VA_W-1 of `req_va` must all be equal. If they are not, the walk faults with no memory access. This check also applies in mode 0.
- R5: The walk starts at `req_ptbr` with its low 12 bits cleared and uses the most significant index first. Each entry address is the base plus the index times the entry size. An entry address at or above MEM_BYTES faults before it is read.
- R6: In an entry, bit 0 is valid, bits 4:1 are the type, bit 5 is referenced, bit 6 is dirty and bits 10 and up hold the page number. The entry is a table pointer when bit entry[4:0] of 0x0000000A is 1. A table pointer makes the next base equal to the page number times 4096.
- R7: A leaf is checked with a mask selected by entry[4:0]. The masks are, for user read/write/execute, 0x0000AAA0, 0x00008880 and 0x0000A0A0, and for supervisor read/write/execute, 0xAAAAAAA0, 0x88888880 and 0xA0A0A000. The store flag picks write ahead of the fetch flag, which picks execute; otherwise read is checked. A cleared mask bit faults with no write.
- R8: A table pointer at the last level faults. An entry that is neither a table pointer nor grants the access (including any entry with bit 0 clear) faults.
- R9: On a granted leaf, the entry is written back to the same address at the same size with bit 5 set, and with bit 6 set too for a store. In mode 0 only that 4-byte half is written.
- R10: For a leaf found with k levels still below it, the result page number is the entry page number ORed with the low k times index-bits bits of the virtual page number.
- R11: A result page base at or above MEM_BYTES faults. The write-back of R9 has already been done when this happens.
- R12: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held stable until the cycle in which `mem_ack` is 1. For 4-byte reads only `mem_rdata[31:0]` is used.
- R13: A good response gives `resp_pa` as a page base with the low 12 bits zero. A fault response gives `resp_pa` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted this edge |
| req_va | input | VA_W | Virtual address |
| req_sup | input | 1 | Supervisor access |
| req_store | input | 1 | Store access |
| req_fetch | input | 1 | Instruction fetch access |
| req_mode | input | 2 | Translation mode |
| req_ptbr | input | PA_W | Page-table base byte address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Translation failed |
| resp_pa | output | PA_W | Physical page base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | 8-byte access (else 4-byte) |
| mem_addr | output | PA_W | Byte address of entry |
| mem_wdata | output | 64 | Write data (low half for 4-byte) |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Read data, valid with ack |

## Verification
The bench builds the walker with VA_W=64, PA_W=32 and MEM_BYTES=0x10000. Because the memory is this small, a table pointer or a large-page result that lands just past 64 KiB reaches the range faults with only a few entries. The last in-range entry slot at 0xFFF8 is exercised too. With the full 64-bit virtual width, a canonical address with its high bits set and a non-canonical address can both be tried in every mode, including the 32-bit layout. The bench varies the memory acknowledge latency between zero and several wait cycles to exercise the hold rule on the memory port.

// File: rtl/rw_pkg.sv
// Shared definitions for the radix walker: mode encodings, entry field
// positions, permission lookup masks and per-mode geometry.
package rw_pkg;

    localparam int PG_OFS    = 12;                    // page offset bits
    localparam int ENT_W     = 64;                    // widest entry
    localparam int PPN_LSB   = 10;                    // page number position
    localparam int PPN_W     = ENT_W - PPN_LSB;       // 54
    localparam int WIDE_W    = PPN_W + PG_OFS;        // full address arithmetic
    localparam int BIT_REF   = 5;
    localparam int BIT_DIRTY = 6;
    localparam int IDX_MAX   = 10;                    // widest level index

    localparam logic [31:0] LUT_TABLE = 32'h0000_000A;
    localparam logic [31:0] LUT_U_RD  = 32'h0000_AAA0;
    localparam logic [31:0] LUT_U_WR  = 32'h0000_8880;
    localparam logic [31:0] LUT_U_EX  = 32'h0000_A0A0;
    localparam logic [31:0] LUT_S_RD  = 32'hAAAA_AAA0;
    localparam logic [31:0] LUT_S_WR  = 32'h8888_8880;
    localparam logic [31:0] LUT_S_EX  = 32'hA0A0_A000;

    typedef enum logic [1:0] {
        MODE_VA32 = 2'd0,
        MODE_VA39 = 2'd1,
        MODE_VA48 = 2'd2,
        MODE_NONE = 2'd3
    } walk_mode_e;

    typedef struct packed {
        logic       ok;
        logic [2:0] levels;
        logic [3:0] idx_bits;
        logic       wide;
        logic [5:0] va_bits;
    } geom_t;

    typedef enum logic [2:0] {
        W_IDLE, W_START, W_LOOK, W_READ, W_EVAL, W_WRITE, W_RESP
    } wstate_e;

    // Geometry of one translation mode.
    function automatic geom_t geom_of(walk_mode_e m);
        geom_t g;
        g = '{ok: 1'b0, levels: 3'd1, idx_bits: 4'd9, wide: 1'b1, va_bits: 6'd21};
        case (m)
            MODE_VA32: g = '{ok: 1'b1, levels: 3'd2, idx_bits: 4'd10, wide: 1'b0, va_bits: 6'd32};
            MODE_VA39: g = '{ok: 1'b1, levels: 3'd3, idx_bits: 4'd9,  wide: 1'b1, va_bits: 6'd39};
            MODE_VA48: g = '{ok: 1'b1, levels: 3'd4, idx_bits: 4'd9,  wide: 1'b1, va_bits: 6'd48};
            default:   ;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/rw_geom.sv
// Mode decoder and canonical-address check.
// Assumes VA_W is at least 48 so every mode's virtual width fits.
module rw_geom #(
    parameter int VA_W = 64
) (
    input  rw_pkg::walk_mode_e mode,
    input  logic [VA_W-1:0]    va,
    output rw_pkg::geom_t      geom,
    output logic               canon_ok
);
    import rw_pkg::*;

    // Look up the level count, index width and entry size for the mode.
    always_comb geom = geom_of(mode);

    // Every bit from va_bits-1 up to the top must equal the top bit.
    always_comb begin
        canon_ok = 1'b1;
        for (int i = 0; i < VA_W; i++) begin
            if (i >= int'(geom.va_bits) - 1 && va[i] != va[VA_W-1])
                canon_ok = 1'b0;
        end
    end

endmodule

// File: rtl/rw_perm.sv
// Entry classifier: turns the 5-bit valid+type code into a table flag and
// an access grant for the requested access class.
// Assumes store outranks fetch, and read is checked when neither is set.
module rw_perm (
    input  logic [4:0] code,
    input  logic       sup,
    input  logic       store,
    input  logic       fetch,
    output logic       is_table,
    output logic       allow
);
    import rw_pkg::*;

    logic rd_ok, wr_ok, ex_ok;

    // Pick the per-privilege bits for this code.
    always_comb begin
        is_table = LUT_TABLE[code];
        rd_ok    = sup ? LUT_S_RD[code] : LUT_U_RD[code];
        wr_ok    = sup ? LUT_S_WR[code] : LUT_U_WR[code];
        ex_ok    = sup ? LUT_S_EX[code] : LUT_U_EX[code];
    end

    // Select the permission by access class.
    always_comb begin
        if (store)      allow = wr_ok;
        else if (fetch) allow = ex_ok;
        else            allow = rd_ok;
    end

endmodule

// File: rtl/rw_index.sv
// Address arithmetic: entry address for the current level and the large-page
// composition of a leaf page number with the untranslated VPN bits.
// Assumes lvl counts the levels still below the current one.
module rw_index #(
    parameter int VA_W = 64
) (
    input  logic [VA_W-1:0]             va,
    input  logic [1:0]                  lvl,
    input  logic [3:0]                  idx_bits,
    input  logic                        wide,
    input  logic [rw_pkg::WIDE_W-1:0]   base,
    input  logic [rw_pkg::PPN_W-1:0]    ppn,
    output logic [rw_pkg::WIDE_W-1:0]   pte_addr,
    output logic [rw_pkg::WIDE_W-1:0]   page
);
    import rw_pkg::*;

    logic [VA_W-1:0]    shifted;
    logic [IDX_MAX-1:0] idx_mask;
    logic [IDX_MAX-1:0] idx;
    logic [4:0]         span;
    logic [PPN_W-1:0]   vpn_ext;
    logic [PPN_W-1:0]   span_mask;

    // Extract the index of this level and scale it by the entry size.
    always_comb begin
        shifted  = va >> (PG_OFS + int'(lvl) * int'(idx_bits));
        idx_mask = (IDX_MAX'(1) << idx_bits) - IDX_MAX'(1);
        idx      = shifted[IDX_MAX-1:0] & idx_mask;
        pte_addr = base + (wide ? (WIDE_W'(idx) << 3) : (WIDE_W'(idx) << 2));
    end

    // Merge the low VPN bits of the levels below into the leaf page number.
    always_comb begin
        span      = 5'(int'(lvl) * int'(idx_bits));
        vpn_ext   = PPN_W'(va >> PG_OFS);
        span_mask = (PPN_W'(1) << span) - PPN_W'(1);
        page      = {ppn | (vpn_ext & span_mask), {PG_OFS{1'b0}}};
    end

endmodule

// File: rtl/radix_walker.sv
// Top of the radix page-table walker. Accepts one request, walks the table
// level by level through a single-outstanding memory port, writes back the
// referenced/dirty flags of a granted leaf and returns a page base or fault.
// Assumes MEM_BYTES <= 2**PA_W, and that memory holds requests until acked.
module radix_walker #(
    parameter int          VA_W      = 64,
    parameter int          PA_W      = 32,
    parameter logic [63:0] MEM_BYTES = 64'h0000_0001_0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    input  logic            req_sup,
    input  logic            req_store,
    input  logic            req_fetch,
    input  logic [1:0]      req_mode,
    input  logic [PA_W-1:0] req_ptbr,
    output logic            resp_valid,
    output logic            resp_fault,
    output logic [PA_W-1:0] resp_pa,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_wide,
    output logic [PA_W-1:0] mem_addr,
    output logic [63:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [63:0]     mem_rdata
);
    import rw_pkg::*;

    localparam logic [WIDE_W-1:0] LIMIT = WIDE_W'(MEM_BYTES);

    wstate_e              st_q;
    walk_mode_e           mode_q;
    logic [VA_W-1:0]      va_q;
    logic                 sup_q, store_q, fetch_q;
    logic [WIDE_W-1:0]    base_q;
    logic [1:0]           lvl_q;
    logic [ENT_W-1:0]     ent_q;
    logic [PA_W-1:0]      addr_q;
    logic [63:0]          wdata_q;
    logic                 req_q, we_q;
    logic                 fault_q;
    logic [PA_W-1:0]      pa_q;

    geom_t                geom;
    logic                 canon_ok;
    logic                 is_table, allow;
    logic [WIDE_W-1:0]    pte_addr, page;
    logic [PPN_W-1:0]     ppn;

    rw_geom #(.VA_W(VA_W)) u_geom (
        .mode     (mode_q),
        .va       (va_q),
        .geom     (geom),
        .canon_ok (canon_ok)
    );

    rw_perm u_perm (
        .code     (ent_q[4:0]),
        .sup      (sup_q),
        .store    (store_q),
        .fetch    (fetch_q),
        .is_table (is_table),
        .allow    (allow)
    );

    // Page number of the held entry; narrow entries are zero-extended on load.
    always_comb ppn = ent_q[ENT_W-1:PPN_LSB];

    rw_index #(.VA_W(VA_W)) u_index (
        .va       (va_q),
        .lvl      (lvl_q),
        .idx_bits (geom.idx_bits),
        .wide     (geom.wide),
        .base     (base_q),
        .ppn      (ppn),
        .pte_addr (pte_addr),
        .page     (page)
    );

    // Walk sequencer: one state per step of the translation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= W_IDLE;
            mode_q  <= MODE_NONE;
            va_q    <= '0;
            sup_q   <= 1'b0;
            store_q <= 1'b0;
            fetch_q <= 1'b0;
            base_q  <= '0;
            lvl_q   <= '0;
            ent_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            case (st_q)
                W_IDLE: if (req_valid) begin
                    mode_q  <= walk_mode_e'(req_mode);
                    va_q    <= req_va;
                    sup_q   <= req_sup;
                    store_q <= req_store;
                    fetch_q <= req_fetch;
                    base_q  <= WIDE_W'({req_ptbr[PA_W-1:PG_OFS], {PG_OFS{1'b0}}});
                    fault_q <= 1'b0;
                    pa_q    <= '0;
                    st_q    <= W_START;
                end
                W_START: begin
                    lvl_q <= 2'(geom.levels - 3'd1);
                    if (!geom.ok || !canon_ok) begin
                        fault_q <= 1'b1;
                        st_q    <= W_RESP;
                    end else begin
                        st_q    <= W_LOOK;
                    end
                end
                W_LOOK: begin
                    if (pte_addr >= LIMIT) begin
                        fault_q <= 1'b1;
                        st_q    <= W_RESP;
                    end else begin
                        addr_q  <= pte_addr[PA_W-1:0];
                        req_q   <= 1'b1;
                        we_q    <= 1'b0;
                        st_q    <= W_READ;
                    end
                end
                W_READ: if (mem_ack) begin
                    ent_q <= geom.wide ? mem_rdata : {32'b0, mem_rdata[31:0]};
                    req_q <= 1'b0;
                    st_q  <= W_EVAL;
                end
                W_EVAL: begin
                    if (is_table) begin
                        if (lvl_q == 2'd0) begin
                            fault_q <= 1'b1;
                            st_q    <= W_RESP;
                        end else begin
                            base_q  <= {ppn, {PG_OFS{1'b0}}};
                            lvl_q   <= lvl_q - 2'd1;
                            st_q    <= W_LOOK;
                        end
                    end else if (!allow) begin
                        fault_q <= 1'b1;
                        st_q    <= W_RESP;
                    end else begin
                        wdata_q <= ent_q | (ENT_W'(1) << BIT_REF)
                                         | (ENT_W'(store_q) << BIT_DIRTY);
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                        st_q    <= W_WRITE;
                    end
                end
                W_WRITE: if (mem_ack) begin
                    req_q <= 1'b0;
                    we_q  <= 1'b0;
                    if (page >= LIMIT) fault_q <= 1'b1;
                    else               pa_q    <= page[PA_W-1:0];
                    st_q  <= W_RESP;
                end
                W_RESP: st_q <= W_IDLE;
                default: st_q <= W_IDLE;
            endcase
        end
    end

    // Drive the ports from the held state.
    always_comb begin
        req_ready  = (st_q == W_IDLE);
        resp_valid = (st_q == W_RESP);
        resp_fault = fault_q;
        resp_pa    = pa_q;
        mem_req    = req_q;
        mem_we     = we_q;
        mem_wide   = geom.wide;
        mem_addr   = addr_q;
        mem_wdata  = wdata_q;
    end

    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_mem_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (64'(mem_addr) < MEM_BYTES));

    p_page_base_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_pa[PG_OFS-1:0] == '0
                                         && 64'(resp_pa) < MEM_BYTES));

    p_fault_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_pa == '0));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !resp_valid));

endmodule

// File: tb/sim_radix_walker.sv
`timescale 1ns/1ps
module sim_radix_walker;

    localparam int          VA_W = 64;
    localparam int          PA_W = 32;
    localparam logic [63:0] MEMB = 64'h1_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_va = '0;
    logic            req_sup = 1'b0, req_store = 1'b0, req_fetch = 1'b0;
    logic [1:0]      req_mode = 2'd0;
    logic [PA_W-1:0] req_ptbr = '0;
    logic            resp_valid, resp_fault;
    logic [PA_W-1:0] resp_pa;
    logic            mem_req, mem_we, mem_wide;
    logic [PA_W-1:0] mem_addr;
    logic [63:0]     mem_wdata;
    logic            mem_ack = 1'b0;
    logic [63:0]     mem_rdata = '0;

    logic [63:0] mem [0:8191];
    int n_cmp = 0, n_bad = 0, n_rd = 0, n_wr = 0, lat = 0, wait_n = 0;
    logic        r_fault;
    logic [31:0] r_pa;

    always #2 clk = ~clk;

    radix_walker #(.VA_W(VA_W), .PA_W(PA_W), .MEM_BYTES(MEMB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_sup(req_sup), .req_store(req_store),
        .req_fetch(req_fetch), .req_mode(req_mode), .req_ptbr(req_ptbr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledges after lat wait cycles; narrow reads put junk high.
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wait_n >= lat) begin
                wait_n = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    n_wr++;
                    if (mem_wide) mem[mem_addr[15:3]] = mem_wdata;
                    else if (mem_addr[2]) mem[mem_addr[15:3]][63:32] = mem_wdata[31:0];
                    else mem[mem_addr[15:3]][31:0] = mem_wdata[31:0];
                end else begin
                    n_rd++;
                    if (mem_wide) mem_rdata = mem[mem_addr[15:3]];
                    else if (mem_addr[2]) mem_rdata = {32'hFFFF_FFFF, mem[mem_addr[15:3]][63:32]};
                    else mem_rdata = {32'hFFFF_FFFF, mem[mem_addr[15:3]][31:0]};
                end
            end else begin
                wait_n++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 8192; i++) mem[i] = '0;
    endtask

    // Run one walk; results in r_fault/r_pa. Checks the R2 handshake on the way.
    task automatic walk(input logic [63:0] va, input logic sup, input logic st,
                        input logic fe, input logic [1:0] mode, input logic [31:0] ptbr);
        int n;
        @(negedge clk);
        req_va = va; req_sup = sup; req_store = st; req_fetch = fe;
        req_mode = mode; req_ptbr = ptbr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after accept", {63'b0, req_ready}, 64'd0);
        n = 0;
        while (!resp_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R2 response seen", {63'b0, resp_valid}, 64'd1);
        r_fault = resp_fault;
        r_pa    = resp_pa;
        @(negedge clk);
        chk("R2 single pulse and ready", {62'b0, resp_valid, req_ready}, 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 ready in reset", {63'b0, req_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {61'b0, req_ready, resp_valid, mem_req}, 64'd4);
    endtask

    task automatic t_three_level();
        int rd0, wr0;
        clear_mem(); lat = 2;
        mem['h201] = 64'h801; mem['h402] = 64'hC01; mem['h603] = 64'h1C0F;
        rd0 = n_rd; wr0 = n_wr;
        walk(64'h4040_3123, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1000);
        chk("R3 three-level fault", {63'b0, r_fault}, 64'd0);
        chk("R6 three-level pa", 64'(r_pa), 64'h7000);
        chk("R5 three reads", 64'(n_rd - rd0), 64'd3);
        chk("R9 referenced set on load", mem['h603], 64'h1C2F);
        wr0 = n_wr;
        walk(64'h4040_3123, 1'b1, 1'b1, 1'b0, 2'd1, 32'h1ABC);
        chk("R5 low ptbr bits ignored", {r_fault, r_pa}, {1'b0, 32'h7000});
        chk("R9 dirty set on store", mem['h603], 64'h1C6F);
        chk("R9 one write", 64'(n_wr - wr0), 64'd1);
    endtask

    task automatic t_superpage();
        int rd0, wr0;
        clear_mem(); lat = 0;
        mem['h201] = 64'h801; mem['h402] = 64'h241F;
        rd0 = n_rd;
        walk(64'h4040_3123, 1'b1, 1'b0, 1'b0, 2'd1, 32'h1000);
        chk("R10 OR merge of vpn", {r_fault, r_pa}, {1'b0, 32'hB000});
        chk("R10 two reads", 64'(n_rd - rd0), 64'd2);
        mem['h201] = 64'h1F;
        walk(64'h4000_5000, 1'b1, 1'b0, 1'b0, 2'd1, 32'h1000);
        chk("R10 top-level large page", {r_fault, r_pa}, {1'b0, 32'h5000});
        mem['h201] = 64'h801; mem['h402] = 64'h201F;
        wr0 = n_wr;
        walk(64'h4041_0000, 1'b1, 1'b0, 1'b0, 2'd1, 32'h1000);
        chk("R11 result beyond memory", {r_fault, r_pa}, {1'b1, 32'h0});
        chk("R11 write-back before range fault", mem['h402], 64'h203F);
        chk("R11 write count", 64'(n_wr - wr0), 64'd1);
    endtask

    task automatic t_narrow();
        int wr0, rd0;
        clear_mem(); lat = 1;
        mem['h802] = {32'h0000_1401, 32'h0};
        mem['hA03] = {32'hDEAD_BEEF, 32'h0000_2805};
        rd0 = n_rd;
        walk(64'h0140_6045, 1'b0, 1'b0, 1'b1, 2'd0, 32'h4000);
        chk("R3 two-level user fetch", {r_fault, r_pa}, {1'b0, 32'hA000});
        chk("R3 two reads", 64'(n_rd - rd0), 64'd2);
        chk("R9 narrow write keeps neighbour", mem['hA03], {32'hDEAD_BEEF, 32'h0000_2825});
        wr0 = n_wr;
        walk(64'h0140_6045, 1'b1, 1'b0, 1'b1, 2'd0, 32'h4000);
        chk("R7 supervisor fetch denied", {63'b0, r_fault}, 64'd1);
        walk(64'h0140_6045, 1'b0, 1'b1, 1'b1, 2'd0, 32'h4000);
        chk("R7 store outranks fetch", {63'b0, r_fault}, 64'd1);
        chk("R7 no write on denial", 64'(n_wr - wr0), 64'd0);
        chk("R7 entry untouched", mem['hA03], {32'hDEAD_BEEF, 32'h0000_2825});
        rd0 = n_rd;
        walk(64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h4000);
        chk("R4 two-level non-canonical", {63'b0, r_fault}, 64'd1);
        chk("R4 no read", 64'(n_rd - rd0), 64'd0);
        mem['hA03] = {32'h0, 32'h0000_0001};
        rd0 = n_rd;
        walk(64'h0140_6045, 1'b0, 1'b0, 1'b0, 2'd0, 32'h4000);
        chk("R8 table at last level", {r_fault, r_pa}, {1'b1, 32'h0});
        chk("R8 two reads", 64'(n_rd - rd0), 64'd2);
        mem['h802] = {32'h0000_1400, 32'h0};
        rd0 = n_rd; wr0 = n_wr;
        walk(64'h0140_6045, 1'b0, 1'b0, 1'b0, 2'd0, 32'h4000);
        chk("R8 invalid entry", {63'b0, r_fault}, 64'd1);
        chk("R8 stops after one read", 64'(n_rd - rd0), 64'd1);
        chk("R8 no write", 64'(n_wr - wr0), 64'd0);
    endtask

    task automatic t_four_level();
        int rd0, wr0;
        clear_mem(); lat = 3;
        mem['hD00] = 64'h2001; mem['h1000] = 64'h2401;
        mem['h1200] = 64'h3001; mem['h1801] = 64'h3409;
        rd0 = n_rd;
        walk(64'hFFFF_8000_0000_1000, 1'b1, 1'b0, 1'b0, 2'd2, 32'h6000);
        chk("R3 four-level pa", {r_fault, r_pa}, {1'b0, 32'hD000});
        chk("R3 four reads", 64'(n_rd - rd0), 64'd4);
        chk("R9 four-level referenced", mem['h1801], 64'h3429);
        wr0 = n_wr;
        walk(64'hFFFF_8000_0000_1000, 1'b1, 1'b1, 1'b0, 2'd2, 32'h6000);
        chk("R7 read-only store denied", {63'b0, r_fault}, 64'd1);
        chk("R7 no write", 64'(n_wr - wr0), 64'd0);
        rd0 = n_rd;
        walk(64'h0000_8000_0000_0000, 1'b1, 1'b0, 1'b0, 2'd2, 32'h6000);
        chk("R4 four-level non-canonical", {63'b0, r_fault}, 64'd1);
        walk(64'h0000_0040_0000_0000, 1'b1, 1'b0, 1'b0, 2'd1, 32'h6000);
        chk("R4 three-level non-canonical", {63'b0, r_fault}, 64'd1);
        walk(64'h0, 1'b1, 1'b0, 1'b0, 2'd3, 32'h6000);
        chk("R3 unsupported mode", {r_fault, r_pa}, {1'b1, 32'h0});
        chk("R3 R4 no reads", 64'(n_rd - rd0), 64'd0);
    endtask

    task automatic t_bounds();
        int rd0;
        clear_mem(); lat = 0;
        rd0 = n_rd;
        walk(64'h4040_3123, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1_0000);
        chk("R5 base beyond memory", {63'b0, r_fault}, 64'd1);
        chk("R5 no read", 64'(n_rd - rd0), 64'd0);
        mem['h201] = 64'h8001;
        rd0 = n_rd;
        walk(64'h4040_3123, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1000);
        chk("R5 table beyond memory", {63'b0, r_fault}, 64'd1);
        chk("R5 one read", 64'(n_rd - rd0), 64'd1);
        rd0 = n_rd;
        walk(64'hFFFF_FFFF_C000_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'hF000);
        chk("R5 last slot read", 64'(n_rd - rd0), 64'd1);
        chk("R8 empty last slot", {63'b0, r_fault}, 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_three_level();
        t_superpage();
        t_narrow();
        t_four_level();
        t_bounds();
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule